// File: doc/BRIEF.md
# Modem Handshake Status and Control Register

This block is the modem handshake part of one serial channel. It takes four active-low modem inputs: clear to send, data set ready, ring indicator and carrier detect. It brings each one into the clock domain through a two-flop synchronizer. A status register shows the current active-high level of each input, together with a sticky change flag per input. Reading the status register clears the change flags. A control register drives the active-low request-to-send and terminal-ready outputs. A local loop mode in that register disconnects the outputs and feeds the control bits back into the status path, so software can exercise the handshake without a modem attached.

An enable register lets any pending change flag raise the channel interrupt. The interrupt pin is split into a level (`irq_out`) and an output enable (`irq_oe`), which a pad cell turns into a three-state driver. The enable comes from a control-register bit. The CPU side is a plain bus with a 3-bit register address, a chip select and read and write strobes that each last one cycle. Data is read combinationally in the cycle of the strobe, and writes take effect at the clock edge. There is no streaming data here, so no valid/ready handshake is used.

Top module: `modem_hs_ctl`

## Requirements
- R1: The status register at address 6 shows the active-high levels clear-to-send at bit 4, data-set-ready at bit 5, ring at bit 6 and carrier detect at bit 7, each equal to the inverted pin. Outside loop mode, a pin change becomes visible in the second cycle after the clock edge that first samples it (two synchronizer flops).
- R2: Change flags are bit 0 for clear-to-send, bit 1 for data-set-ready and bit 3 for carrier detect, and each sets on any change of its level. Bit 2 sets only when the ring level falls from 1 to 0 (ring pin returning high). A flag sets at the edge that ends the cycle in which the new level is first shown.
- R3: A read of address 6 clears all four change flags at the edge that ends the read cycle. A change detected in that same cycle leaves its flag set.
- R4: Bit 3 of the enable register at address 1 enables the modem interrupt, and the request is that bit ANDed with the OR of the four change flags.
- R5: `dtr_n` is the inverse of control bit 0 and `rts_n` is the inverse of control bit 1 (control register at address 4). Both are forced high while loop bit 4 is set, and both are high after reset.
- R6: With loop bit 4 set, the status levels come from the control register with no synchronizer delay: clear-to-send from bit 1, data-set-ready from bit 0, ring from bit 2 and carrier detect from bit 3.
- R7: `irq_oe` equals control bit 3. `irq_out` is 1 only when `irq_oe` is 1 and the request of R4 is active, and 0 otherwise.
- R8: Address 4 reads back control bits 4:0 with bits 7:5 as 0, and address 1 reads back only bit 3. Other addresses read 0, and `rdata` is 0 whenever no read is selected. A write without `cs`, or to any other address, changes no register.
- R9: Reset clears the control register, the enable bit and all change flags, and brings the synchronizers to the inactive level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Channel select |
| rd_en | input | 1 | Read strobe, one cycle |
| wr_en | input | 1 | Write strobe, one cycle |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the strobe cycle |
| cts_n | input | 1 | Clear to send, active low |
| dsr_n | input | 1 | Data set ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| rts_n | output | 1 | Request to send, active low |
| dtr_n | output | 1 | Terminal ready, active low |
| irq_out | output | 1 | Interrupt level, active high |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The assertions check on every cycle that the modem outputs stay idle in loop mode and that the interrupt stays low when its output enable is off or no enabled flag is pending. They also check that a status read with no coincident change empties the flags, and that no flag is lost outside a read. The bench scenarios cover everything that depends on event order and timing: the two-cycle synchronizer latency, the ring flag setting only on the trailing edge, a change that lands in the same cycle as the clearing read, and the immediate feedback in loop mode. A cycle-level reference model run under random bus traffic and pin toggling checks these scenarios and the read-back values.

// File: rtl/modem_hs_pkg.sv
package modem_hs_pkg;
  localparam int unsigned AW = 3;
  localparam int unsigned DW = 8;
  localparam int unsigned NSIG = 4;           // cts, dsr, ri, dcd in index order
  localparam logic [AW-1:0] A_ENABLE = 3'd1;
  localparam logic [AW-1:0] A_CTRL   = 3'd4;
  localparam logic [AW-1:0] A_STATUS = 3'd6;
  localparam int unsigned B_DTR  = 0;
  localparam int unsigned B_RTS  = 1;
  localparam int unsigned B_AUX  = 2;
  localparam int unsigned B_IRQE = 3;
  localparam int unsigned B_LOOP = 4;
  localparam int unsigned CTRL_W = 5;
  localparam int unsigned B_MSIE = 3;
  localparam logic [NSIG-1:0] TRAIL_ONLY = 4'b0100;   // ring flags on falling level
endpackage

// File: rtl/modem_hs_sync.sv
module modem_hs_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/modem_hs_delta.sv
module modem_hs_delta #(
  parameter int unsigned  W     = 4,
  parameter logic [W-1:0] TRAIL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic         clr,
  output logic [W-1:0] chg,
  output logic [W-1:0] flags
);
  logic [W-1:0] prev_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_edge
      if (TRAIL[i]) begin : g_fall
        assign chg[i] = prev_q[i] & ~lvl[i];
      end else begin : g_any
        assign chg[i] = prev_q[i] ^ lvl[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flags  <= '0;
    end else begin
      prev_q <= lvl;
      // a change seen in the clearing cycle wins over the clear
      flags  <= (flags & ~{W{clr}}) | chg;
    end
  end
endmodule

// File: rtl/modem_hs_regs.sv
module modem_hs_regs
  import modem_hs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [CTRL_W-1:0] wctrl,
  input  logic              wmsie,
  output logic [CTRL_W-1:0] ctrl,
  output logic              msie
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      msie <= 1'b0;
    end else if (we) begin
      if (addr == A_CTRL)   ctrl <= wctrl;
      if (addr == A_ENABLE) msie <= wmsie;
    end
  end
endmodule

// File: rtl/modem_hs_ctl.sv
module modem_hs_ctl
  import modem_hs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          cts_n,
  input  logic          dsr_n,
  input  logic          ri_n,
  input  logic          dcd_n,
  output logic          rts_n,
  output logic          dtr_n,
  output logic          irq_out,
  output logic          irq_oe
);
  logic [NSIG-1:0]   pin_act;
  logic [NSIG-1:0]   pin_lvl;
  logic [NSIG-1:0]   loop_lvl;
  logic [NSIG-1:0]   lvl;
  logic [NSIG-1:0]   chg;
  logic [NSIG-1:0]   flags;
  logic [CTRL_W-1:0] ctrl;
  logic              msi_en;
  logic              loop_en;
  logic              rd_msr;
  logic              wr_hit;
  logic              unused_wdata;

  assign unused_wdata = ^{wdata[DW-1:CTRL_W], wdata[2:0]};

  assign pin_act = ~{dcd_n, ri_n, dsr_n, cts_n};

  modem_hs_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_act), .q(pin_lvl)
  );

  assign wr_hit = cs & wr_en;

  modem_hs_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_hit), .addr(addr),
    .wctrl(wdata[CTRL_W-1:0]), .wmsie(wdata[B_MSIE]),
    .ctrl(ctrl), .msie(msi_en)
  );

  assign loop_en  = ctrl[B_LOOP];
  assign loop_lvl = {ctrl[B_IRQE], ctrl[B_AUX], ctrl[B_DTR], ctrl[B_RTS]};
  assign lvl      = loop_en ? loop_lvl : pin_lvl;
  assign rd_msr   = cs & rd_en & (addr == A_STATUS);

  modem_hs_delta #(.W(NSIG), .TRAIL(TRAIL_ONLY)) u_delta (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .clr(rd_msr),
    .chg(chg), .flags(flags)
  );

  always_comb begin
    rdata = '0;
    if (cs && rd_en) begin
      unique case (addr)
        A_STATUS: rdata = {lvl, flags};
        A_CTRL:   rdata = {{(DW-CTRL_W){1'b0}}, ctrl};
        A_ENABLE: rdata[B_MSIE] = msi_en;
        default:  rdata = '0;
      endcase
    end
  end

  assign dtr_n   = ~(ctrl[B_DTR] & ~loop_en);
  assign rts_n   = ~(ctrl[B_RTS] & ~loop_en);
  assign irq_oe  = ctrl[B_IRQE];
  assign irq_out = ctrl[B_IRQE] & msi_en & (|flags);
endmodule

// File: rtl/modem_hs_ctl_chk.sv
module modem_hs_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_msr,
  input logic [3:0] chg,
  input logic [3:0] flags,
  input logic       msi_en,
  input logic       loop_en,
  input logic       rts_n,
  input logic       dtr_n,
  input logic       irq_out,
  input logic       irq_oe
);
  a_r5_loop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (rts_n && dtr_n));

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_oe |-> !irq_out);

  a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (msi_en && (flags != 4'b0)));

  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msr && chg == 4'b0) |=> (flags == 4'b0));

  a_r3_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_msr |=> ((flags & $past(flags)) == $past(flags)));

  a_r3_change_kept: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(chg)) == $past(chg)));
endmodule

bind modem_hs_ctl modem_hs_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_msr(rd_msr), .chg(chg), .flags(flags),
  .msi_en(msi_en), .loop_en(loop_en), .rts_n(rts_n), .dtr_n(dtr_n),
  .irq_out(irq_out), .irq_oe(irq_oe)
);

// File: tb/modem_hs_ctl_bench.sv
module modem_hs_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic       rts_n, dtr_n, irq_out, irq_oe;

  int unsigned n_run = 0, n_fail = 0;

  // reference model state
  logic [3:0] m_s1 = '0, m_s2 = '0, m_pv = '0, m_fl = '0;
  logic [4:0] m_ctrl = '0;
  logic       m_ie = 1'b0;

  always #5 clk = ~clk;

  modem_hs_ctl u_modem_hs_ctl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .rts_n(rts_n), .dtr_n(dtr_n), .irq_out(irq_out), .irq_oe(irq_oe)
  );

  function automatic logic [3:0] m_lvl();
    return m_ctrl[4] ? {m_ctrl[3], m_ctrl[2], m_ctrl[0], m_ctrl[1]} : m_s2;
  endfunction

  function automatic logic [3:0] m_chg();
    logic [3:0] l = m_lvl();
    return {m_pv[3] ^ l[3], m_pv[2] & ~l[2], m_pv[1] ^ l[1], m_pv[0] ^ l[0]};
  endfunction

  function automatic logic [7:0] m_rd(input logic c, input logic r, input logic [2:0] a);
    if (!(c && r)) return 8'h00;
    case (a)
      3'd6: return {m_lvl(), m_fl};
      3'd4: return {3'b000, m_ctrl};
      3'd1: return {4'b0000, m_ie, 3'b000};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  logic [7:0] last_rd;

  // called at a falling edge: drive, check, advance one clock
  task automatic step(input logic c, input logic r, input logic w,
                      input logic [2:0] a, input logic [7:0] d, input logic [3:0] inn);
    cs = c; rd_en = r; wr_en = w; addr = a; wdata = d;
    {dcd_n, ri_n, dsr_n, cts_n} = inn;
    #1;
    last_rd = rdata;
    chk((a == 3'd6) ? "R1 R2 R3 status read" : "R8 register read", rdata, m_rd(c, r, a));
    chk("R5 modem outputs", {6'b0, rts_n, dtr_n},
        {6'b0, ~(m_ctrl[1] & ~m_ctrl[4]), ~(m_ctrl[0] & ~m_ctrl[4])});
    chk("R4 R7 interrupt pin", {6'b0, irq_oe, irq_out},
        {6'b0, m_ctrl[3], m_ctrl[3] & m_ie & (|m_fl)});
    @(posedge clk);
    begin
      logic [3:0] ch = m_chg();
      m_fl = (m_fl & ~{4{c & r & (a == 3'd6)}}) | ch;
      m_pv = m_lvl();
      m_s2 = m_s1;
      m_s1 = ~inn;
      if (c && w && a == 3'd4) m_ctrl = d[4:0];
      if (c && w && a == 3'd1) m_ie = d[3];
    end
    @(negedge clk);
    cs = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic idle(input logic [3:0] inn);
    step(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, inn);
  endtask

  task automatic rd(input logic [2:0] a, input logic [3:0] inn);
    step(1'b1, 1'b1, 1'b0, a, 8'h00, inn);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic [3:0] inn);
    step(1'b1, 1'b0, 1'b1, a, d, inn);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [3:0] pins;
    void'($urandom(32'd2024));
    pins = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    rd(3'd6, pins); chk("R9 status after reset", last_rd, 8'h00);
    rd(3'd4, pins); chk("R9 control after reset", last_rd, 8'h00);
    chk("R9 outputs after reset", {4'b0, rts_n, dtr_n, irq_oe, irq_out}, 8'h0C);

    // R1 / R3 latency and same-cycle change with clearing read
    pins = 4'b1110;               // cts_n low
    idle(pins);
    idle(pins);
    rd(3'd6, pins); chk("R1 cts level after two flops, flag not yet", last_rd, 8'h10);
    rd(3'd6, pins); chk("R3 change during read kept", last_rd, 8'h11);
    rd(3'd6, pins); chk("R3 flag cleared by read", last_rd, 8'h10);

    // R2 ring flags only on trailing edge
    pins = 4'b1010;               // ring active
    repeat (3) idle(pins);
    rd(3'd6, pins); chk("R2 ring leading edge sets no flag", last_rd, 8'h50);
    pins = 4'b1110;
    repeat (3) idle(pins);
    rd(3'd6, pins); chk("R2 ring trailing edge sets bit 2", last_rd, 8'h14);

    // R8 ignored writes
    step(1'b0, 1'b0, 1'b1, 3'd4, 8'h1F, pins);
    wr(3'd5, 8'hFF, pins);
    rd(3'd4, pins); chk("R8 write without cs or to other address ignored", last_rd, 8'h00);

    // R5 / R6 loop mode
    wr(3'd4, 8'h12, pins);
    chk("R5 rts and dtr idle in loop", {6'b0, rts_n, dtr_n}, 8'h03);
    rd(3'd6, pins); chk("R6 loop feeds rts to cts at once", {4'b0, last_rd[7:4]}, 8'h01);
    wr(3'd4, 8'h1D, pins);
    rd(3'd6, pins); chk("R6 loop feeds dtr, aux, irq-enable bits", {4'b0, last_rd[7:4]}, 8'h0E);

    // R4 / R7 interrupt gating
    wr(3'd1, 8'h08, pins);
    wr(3'd4, 8'h0B, pins);        // leave loop, outputs on, pin enabled
    idle(pins);
    chk("R4 R7 pending flag raises irq", {6'b0, irq_oe, irq_out}, 8'h03);
    wr(3'd4, 8'h03, pins);
    chk("R7 disabled pin holds irq low", {6'b0, irq_oe, irq_out}, 8'h00);
    rd(3'd6, pins);
    wr(3'd4, 8'h0B, pins);
    chk("R4 cleared flags drop irq", {6'b0, irq_oe, irq_out}, 8'h02);

    // random traffic against the model
    for (int k = 0; k < 4000; k++) begin
      logic [2:0] a;
      int unsigned sel = $urandom % 8;
      for (int b = 0; b < 4; b++) if (($urandom % 8) == 0) pins[b] = ~pins[b];
      case ($urandom % 4)
        0: a = 3'd6;
        1: a = 3'd4;
        2: a = 3'd1;
        default: a = 3'($urandom);
      endcase
      if (sel < 3)      step(1'b1, 1'b1, 1'b0, a, 8'h00, pins);
      else if (sel < 4) step(1'b1, 1'b0, 1'b1, a, 8'($urandom), pins);
      else if (sel < 5) step(1'b0, 1'($urandom), 1'($urandom), a, 8'($urandom), pins);
      else              idle(pins);
    end
    summary();
  end
endmodule